// File: doc/BRIEF.md
# Interrupt Latch and Start-up Reset Sequencer

This block sits between the oscillator, the power-on reset and the external interrupt pin of a small 8-bit microcontroller core, and produces three things for the core. The first is a clock enable that marks every second oscillator cycle, so that the processor advances at half the oscillator rate. The second is a core reset that stays asserted for a fixed number of internal cycles after power-on and again after the core leaves STOP mode. The third is an interrupt-take strobe.

The external request pin is active low. A falling edge on it, seen after a synchronizer, records a pending request in a latch. The latch is offered to the core only on the cycle that ends an instruction, and only while the condition-code mask bit is clear. An acknowledge clears the latch. If the pin is still held low at that moment, the latch stays set, so a sustained low level keeps producing interrupts.

Top module: `irq_reset_seq`

## Requirements
- R1: `clk_en` is 0 while reset is applied and, once the internal reset is released, toggles on every oscillator edge. An edge at which `clk_en` was 1 just before it is one internal cycle, a "tick".
- R2: `core_reset` is 1 while `rst_n` is low. After `rst_n` rises, it stays 1 until exactly STARTUP_CYCLES+1 ticks have occurred, and then falls to 0.
- R3: A one-cycle `stop_exit` pulse sets `core_reset` to 1 at the next edge, even when a delay is already running. It then holds `core_reset` high for exactly STARTUP_CYCLES+1 further ticks, counted from zero.
- R4: A low pulse on `irq_n` of at least two oscillator cycles is detected as a 1-to-0 transition of the synchronized pin. It sets a pending request, which is held for any number of cycles until acknowledged.
- R5: `take_irq` is 1 in a cycle exactly when `instr_end` is 1, `i_mask` is 0, a request is pending and `core_reset` is 0. It responds combinationally within that cycle.
- R6: While `core_reset` is 1, `take_irq` is 0. A request that arrives during the delay is kept and offered after the delay ends.
- R7: `irq_ack` clears the pending request at the next edge, unless the synchronized pin is low at that edge, in which case the request stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| stop_exit | input | 1 | One-cycle pulse when the core leaves STOP mode |
| irq_n | input | 1 | External interrupt pin, active low, asynchronous |
| instr_end | input | 1 | Core marks the last cycle of an instruction |
| i_mask | input | 1 | Interrupt mask bit from the condition code register |
| irq_ack | input | 1 | Core acknowledges the taken interrupt |
| clk_en | output | 1 | Internal clock enable, half the oscillator rate |
| core_reset | output | 1 | Holds the core in reset, active high |
| take_irq | output | 1 | Core should begin the interrupt sequence |

## Verification
The bench builds the block with STARTUP_CYCLES set to 12 and a two-stage synchronizer. With that delay, a full power-on sequence, a restart in the middle of a count and a STOP exit that starts from an arbitrary clock phase all fit in a few hundred cycles, and the exact tick count at which reset falls can be compared. The bench counts ticks from the `clk_en` port rather than counting raw cycles, so the expected counts do not depend on the phase of the divider when `stop_exit` arrives.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  typedef enum logic {
    SEQ_HOLD = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/irqseq_clkdiv.sv
module irqseq_clkdiv (
  input  logic clk,
  input  logic rst_n,
  output logic tick_en
);
  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign tick_en = phase_q;
endmodule

// File: rtl/irqseq_startup.sv
module irqseq_startup import irqseq_pkg::*; #(
  parameter int STARTUP_CYCLES = 4064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic restart,
  output logic hold
);
  localparam int CNT_W = $clog2(STARTUP_CYCLES + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STARTUP_CYCLES);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (restart) begin
      state_d = SEQ_HOLD;
      cnt_d   = '0;
    end else if ((state_q == SEQ_HOLD) && tick_en) begin
      if (cnt_q == LIMIT) begin
        state_d = SEQ_RUN;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold = (state_q == SEQ_HOLD);
endmodule

// File: rtl/irqseq_latch.sv
module irqseq_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic ack,
  output logic pending
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q, last_d;
  logic                   pend_q, pend_d;
  logic                   cur;
  logic                   fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = pin_n;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_n};
    end
  endgenerate

  assign cur  = sync_q[SYNC_STAGES-1];
  assign fall = last_q & ~cur;

  always_comb begin
    last_d = cur;
    pend_d = pend_q;
    if (ack) begin
      pend_d = ~cur;
    end
    if (fall) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irq_reset_seq.sv
module irq_reset_seq #(
  parameter int STARTUP_CYCLES = 4064,
  parameter int SYNC_STAGES    = 2,
  parameter int RST_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_exit,
  input  logic irq_n,
  input  logic instr_end,
  input  logic i_mask,
  input  logic irq_ack,
  output logic clk_en,
  output logic core_reset,
  output logic take_irq
);
  logic [RST_STAGES-1:0] rs_q;
  logic                  sys_rst_n;
  logic                  pending;
  logic                  hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign sys_rst_n = rs_q[RST_STAGES-1];

  irqseq_clkdiv u_div (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .tick_en (clk_en)
  );

  irqseq_startup #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_start (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .tick_en (clk_en),
    .restart (stop_exit),
    .hold    (hold)
  );

  irqseq_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .pin_n   (irq_n),
    .ack     (irq_ack),
    .pending (pending)
  );

  assign core_reset = hold;
  assign take_irq   = instr_end & ~i_mask & pending & ~hold;
endmodule

// File: rtl/irq_reset_seq_chk.sv
module irq_reset_seq_chk (
  input logic clk,
  input logic sys_rst_n,
  input logic stop_exit,
  input logic instr_end,
  input logic i_mask,
  input logic clk_en,
  input logic core_reset,
  input logic take_irq
);
  p_clk_en_toggle_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    1'b1 |=> (clk_en != $past(clk_en)));

  p_rise_only_on_stop_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(core_reset) |-> $past(stop_exit));

  p_stop_holds_core_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    stop_exit |=> core_reset);

  p_take_at_boundary_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    take_irq |-> (instr_end && !i_mask));

  p_no_take_in_reset_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    core_reset |-> !take_irq);
endmodule

bind irq_reset_seq irq_reset_seq_chk u_chk (
  .clk        (clk),
  .sys_rst_n  (sys_rst_n),
  .stop_exit  (stop_exit),
  .instr_end  (instr_end),
  .i_mask     (i_mask),
  .clk_en     (clk_en),
  .core_reset (core_reset),
  .take_irq   (take_irq)
);

// File: tb/irq_reset_seq_test.sv
module irq_reset_seq_test;
  localparam int STARTUP = 12;

  logic clk;
  logic rst_n;
  logic stop_exit;
  logic irq_n;
  logic instr_end;
  logic i_mask;
  logic irq_ack;
  logic clk_en;
  logic core_reset;
  logic take_irq;

  int n_checks;
  int n_fail;
  int cyc;

  irq_reset_seq #(.STARTUP_CYCLES(STARTUP), .SYNC_STAGES(2), .RST_STAGES(2)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_exit  (stop_exit),
    .irq_n      (irq_n),
    .instr_end  (instr_end),
    .i_mask     (i_mask),
    .irq_ack    (irq_ack),
    .clk_en     (clk_en),
    .core_reset (core_reset),
    .take_irq   (take_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // {pulse, mask, iend, expected take}
  localparam logic [3:0] VEC [6] = '{
    4'b1110,
    4'b0000,
    4'b0011,
    4'b0010,
    4'b1011,
    4'b0100
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_irq(input int len);
    irq_n = 1'b0;
    step(len);
    irq_n = 1'b1;
    step(4);
  endtask

  task automatic ack_once();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
  endtask

  task automatic count_ticks(output int ticks);
    ticks = 0;
    while (core_reset === 1'b1 && ticks < 10000) begin
      if (clk_en === 1'b1) ticks++;
      step(1);
    end
  endtask

  initial begin
    int ticks;
    int toggles;
    logic prev;
    n_checks = 0;
    n_fail = 0;
    cyc = 0;
    rst_n = 1'b0;
    stop_exit = 1'b0;
    irq_n = 1'b1;
    instr_end = 1'b0;
    i_mask = 1'b0;
    irq_ack = 1'b0;
    step(3);
    #1;
    check(core_reset === 1'b1, "R2 reset core_reset", int'(core_reset), 1);
    check(clk_en === 1'b0, "R1 reset clk_en", int'(clk_en), 0);
    check(take_irq === 1'b0, "R6 reset take_irq", int'(take_irq), 0);

    // R2: full power-on delay
    rst_n = 1'b1;
    count_ticks(ticks);
    check(ticks == STARTUP + 1, "R2 power-on ticks", ticks, STARTUP + 1);

    // R1: toggling
    toggles = 0;
    prev = clk_en;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (clk_en !== prev) toggles++;
      prev = clk_en;
    end
    check(toggles == 10, "R1 clk_en toggles", toggles, 10);

    // R3: restart in the middle of a count
    rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(10);
    stop_exit = 1'b1;
    step(1);
    stop_exit = 1'b0;
    check(core_reset === 1'b1, "R3 mid-count restart holds", int'(core_reset), 1);
    count_ticks(ticks);
    check(ticks == STARTUP + 1, "R3 mid-count restart ticks", ticks, STARTUP + 1);

    // R3 and R6: stop exit from run, irq during delay
    step(3);
    stop_exit = 1'b1;
    step(1);
    stop_exit = 1'b0;
    check(core_reset === 1'b1, "R3 stop exit asserts reset", int'(core_reset), 1);
    irq_n = 1'b0;
    step(2);
    irq_n = 1'b1;
    step(4);
    instr_end = 1'b1;
    #1;
    check(take_irq === 1'b0, "R6 no take during delay", int'(take_irq), 0);
    instr_end = 1'b0;
    count_ticks(ticks);
    check(ticks >= STARTUP - 6 && ticks <= STARTUP + 1, "R3 stop exit delay", ticks, STARTUP + 1);
    instr_end = 1'b1;
    #1;
    check(take_irq === 1'b1, "R6 pending offered after delay", int'(take_irq), 1);
    ack_once();
    instr_end = 1'b0;

    // R3: exact count from a fresh stop exit
    stop_exit = 1'b1;
    step(1);
    stop_exit = 1'b0;
    count_ticks(ticks);
    check(ticks == STARTUP + 1, "R3 stop exit ticks", ticks, STARTUP + 1);

    // R4, R5, R7: table walk
    foreach (VEC[k]) begin
      if (VEC[k][3]) pulse_irq(2);
      i_mask = VEC[k][2];
      instr_end = VEC[k][1];
      #1;
      check(take_irq === VEC[k][0], $sformatf("R5 vector %0d take", k), int'(take_irq), int'(VEC[k][0]));
      if (VEC[k][0]) ack_once();
      else step(1);
      instr_end = 1'b0;
      i_mask = 1'b0;
    end

    // R4: masked pulse held many cycles
    i_mask = 1'b1;
    pulse_irq(2);
    instr_end = 1'b1;
    step(20);
    #1;
    check(take_irq === 1'b0, "R4 masked stays silent", int'(take_irq), 0);
    i_mask = 1'b0;
    #1;
    check(take_irq === 1'b1, "R4 pending after unmask", int'(take_irq), 1);
    ack_once();
    #1;
    check(take_irq === 1'b0, "R7 ack clears pending", int'(take_irq), 0);
    instr_end = 1'b0;

    // R7: held low level re-arms
    irq_n = 1'b0;
    step(4);
    instr_end = 1'b1;
    #1;
    check(take_irq === 1'b1, "R7 level first take", int'(take_irq), 1);
    ack_once();
    #1;
    check(take_irq === 1'b1, "R7 level repeats", int'(take_irq), 1);
    ack_once();
    #1;
    check(take_irq === 1'b1, "R7 level repeats again", int'(take_irq), 1);
    instr_end = 1'b0;
    irq_n = 1'b1;
    step(4);
    ack_once();
    instr_end = 1'b1;
    #1;
    check(take_irq === 1'b0, "R7 released level cleared", int'(take_irq), 0);
    instr_end = 1'b0;
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule